// File: doc/BRIEF.md
# I2C Register Target with Buffer Drain Port

This block is an I2C target that lets a bus host read and write a bank of 8-bit registers held outside the block. Both bus lines are sampled with the system clock, passed through a two-flop synchroniser and a short glitch filter, and then turned into SCL edge events and start and stop conditions. The host first sends a register index byte. That index loads a 7-bit pointer, which moves forward by one after every transferred byte. Data then moves through a write strobe with address and data, or through a read address with combinational read data returned from the register file.

One index is reserved as a buffer window. While the pointer sits on that index it does not move. Each byte read there takes its value from an external sample FIFO and pulses a pop to advance that FIFO. A startup-complete input gates the whole target. Until it is high, the target refuses its own address with a NACK.

SDA is only ever pulled low through an output enable and is released at all other times. The block never stretches SCL.

Top module: `i2c_regport`

## Requirements
- R1: After reset, with startup complete, the target ACKs an address byte whose upper 7 bits equal the DEV_ADDR parameter. It ACKs every following register index byte and write data byte by holding SDA low through the ninth SCL high phase.
- R2: An address byte with any other 7-bit address gets no ACK, and the target ignores the bus until the next start.
- R3: While startup_done is low, the own address is answered with a NACK, and no register is written by the bytes that follow.
- R4: In a write (R/W bit = 0), the byte after the address sets the pointer. Each later data byte is committed as a single-cycle reg_we pulse, with reg_addr equal to the pointer and reg_wdata equal to the byte.
- R5: Bit 7 of the register index byte is ignored. Index 0x85 selects register 0x05.
- R6: After each committed write byte the pointer advances by one, so consecutive bytes land in consecutive registers.
- R7: In a read (R/W bit = 1), the target sends reg_rdata for the current pointer, MSB first. It advances the pointer after each byte the host ACKs, and stops driving after a host NACK.
- R8: While the pointer equals BUF_ADDR, it does not advance. Each byte sent is taken from fifo_data, with exactly one single-cycle fifo_pop per byte.
- R9: A stop that arrives while the last bit of a write data byte is on the bus commits no write. A write is only committed at the SCL fall that ends that byte's ACK slot.
- R10: A start seen in the middle of any byte abandons that byte, releases SDA and restarts address reception without a stop.
- R11: A stop returns the target to idle with SDA released. Bytes clocked after it without a new start get no ACK.
- R12: During and after reset, sda_oe, reg_we and fifo_pop are low and reg_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when high |
| startup_done | input | 1 | Device ready; address ACK allowed |
| reg_we | output | 1 | Register write strobe, one cycle |
| reg_addr | output | 7 | Register pointer (write and read address) |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for reg_addr |
| fifo_pop | output | 1 | Advance the sample FIFO, one cycle |
| fifo_data | input | 8 | Current FIFO head value |

## Verification
A table of index and value pairs is written one register per transaction and read back. It includes an index with bit 7 set, so a masking fault and a pointer-load fault give different results. Multi-byte writes followed by a multi-byte read separate write-side increment from read-side increment. Reads at the buffer index, followed by a fresh read that sends no index byte, show whether the pointer stayed frozen and whether each byte popped exactly once. Transfers that break off make a premature commit visible as a changed register: a stop in the last data bit, a start in mid-byte, a wrong address, and the own address before startup.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_IDX,
    ST_IDX_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      dout   <= 1'b1;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == dout) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        dout  <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         PTR_W    = 7,
  parameter logic [PTR_W-1:0] BUF_ADDR = 7'h3E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              startup_done,
  input  logic [BYTE_W-1:0] reg_rdata,
  input  logic [BYTE_W-1:0] fifo_data,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              fifo_pop
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  tgt_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              rd_mode, host_ack;
  logic              at_buf;
  logic [BYTE_W-1:0] next_tx;

  assign at_buf  = (reg_addr == BUF_ADDR);
  assign next_tx = at_buf ? fifo_data : reg_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rd_mode   <= 1'b0;
      host_ack  <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      fifo_pop  <= 1'b0;
    end else begin
      reg_we   <= 1'b0;
      fifo_pop <= 1'b0;
      if (reg_we && !at_buf) reg_addr <= reg_addr + 1'b1;

      if (stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_ev) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_IDX, ST_WR: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (rx_sh[BYTE_W-1:1] == DEV_ADDR && startup_done) begin
                  sda_oe  <= 1'b1;
                  rd_mode <= rx_sh[0];
                  state   <= ST_ADDR_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= (state == ST_IDX) ? ST_IDX_ACK : ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            if (rd_mode) begin
              tx_sh    <= next_tx;
              sda_oe   <= ~next_tx[BYTE_W-1];
              fifo_pop <= at_buf;
              state    <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_IDX;
            end
          end
          ST_IDX_ACK: if (scl_fall) begin
            sda_oe   <= 1'b0;
            reg_addr <= rx_sh[PTR_W-1:0];
            state    <= ST_WR;
          end
          ST_WR_ACK: if (scl_fall) begin
            sda_oe    <= 1'b0;
            reg_we    <= 1'b1;
            reg_wdata <= rx_sh;
            state     <= ST_WR;
          end
          ST_RD: if (scl_fall) begin
            if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_RD_ACK;
            end else begin
              tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_oe  <= ~tx_sh[BYTE_W-2];
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_f;
              if (!sda_f && !at_buf) reg_addr <= reg_addr + 1'b1;
            end else if (scl_fall) begin
              if (host_ack) begin
                tx_sh    <= next_tx;
                sda_oe   <= ~next_tx[BYTE_W-1];
                fifo_pop <= at_buf;
                state    <= ST_RD;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter logic [6:0] BUF_ADDR = 7'h3E,
  parameter int         FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       startup_done,
  output logic       reg_we,
  output logic [6:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata,
  output logic       fifo_pop,
  input  logic [7:0] fifo_data
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] lines_raw, lines_f;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign lines_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .din  (lines_raw[g]),
      .dout (lines_f[g])
    );
  end

  assign scl_f = lines_f[0];
  assign sda_f = lines_f[1];

  i2c_bus_events u_ev (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_target_ctrl #(
    .DEV_ADDR (DEV_ADDR),
    .PTR_W    (7),
    .BUF_ADDR (BUF_ADDR)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .sda_f        (sda_f),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_ev     (start_ev),
    .stop_ev      (stop_ev),
    .startup_done (startup_done),
    .reg_rdata    (reg_rdata),
    .fifo_data    (fifo_data),
    .sda_oe       (sda_oe),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .fifo_pop     (fifo_pop)
  );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk #(
  parameter logic [6:0] BUF_ADDR = 7'h3E
) (
  input logic       clk,
  input logic       rst,
  input logic       scl_f,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [6:0] reg_addr,
  input logic       fifo_pop
);
  a_r4_we_single: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  a_r4_we_scl_low: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !scl_f);

  a_r8_pop_single: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop);

  a_r8_pop_at_buf: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> reg_addr == BUF_ADDR);

  a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> $stable(reg_addr));

  a_r8_no_pop_on_write: assert property (@(posedge clk) disable iff (rst)
    !(fifo_pop && reg_we));

  a_r10_start_release: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> !sda_oe);

  a_r11_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_oe);
endmodule

bind i2c_regport i2c_regport_chk #(.BUF_ADDR(BUF_ADDR)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_f    (scl_f),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .sda_oe   (sda_oe),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .fifo_pop (fifo_pop)
);

// File: tb/tb_i2c_regport.sv
module tb_i2c_regport;
  localparam logic [6:0] DEV  = 7'h2A;
  localparam logic [6:0] BUFA = 7'h3E;
  localparam int Q = 10;
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{16'h0112, 16'h02FE, 16'h8533,
                                       16'h7F5A, 16'h4000, 16'h1C81};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, startup_done = 1'b0;
  logic sda_oe, reg_we, fifo_pop;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, fifo_data;
  wire sda_line = sda_m & ~sda_oe;

  logic [7:0] regs [128];
  int pops;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 128; i++) regs[i] <= 8'h00;
      pops <= 0;
    end else begin
      if (reg_we) regs[reg_addr] <= reg_wdata;
      if (fifo_pop) pops <= pops + 1;
    end
  end
  assign reg_rdata = regs[reg_addr];
  assign fifo_data = 8'hA0 + pops[7:0];

  i2c_regport #(.DEV_ADDR(DEV), .BUF_ADDR(BUFA), .FILT_LEN(3)) dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .startup_done(startup_done), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_pop(fifo_pop),
    .fifo_data(fifo_data)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic bit_cycle(input logic drv, output logic smp);
    sda_m = drv; tick(Q);
    scl_m = 1'b1; tick(Q);
    smp = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      b[i] = s;
    end
    bit_cycle(~ack, s);
  endtask

  task automatic wr1(input logic [7:0] ra, input logic [7:0] d);
    logic a0, a1, a2;
    bus_start();
    wr_byte({DEV, 1'b0}, a0);
    wr_byte(ra, a1);
    wr_byte(d, a2);
    bus_stop();
    chk("R1/R4 write acks", {5'b0, a0, a1, a2}, 8'h07);
  endtask

  task automatic rd_setup(input logic [7:0] ra);
    logic a;
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(ra, a);
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    chk("R1 read address ack", {7'b0, a}, 8'h01);
  endtask

  task automatic rd1(input logic [7:0] ra, output logic [7:0] d);
    rd_setup(ra);
    rd_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic a, s;
    logic [7:0] d;
    int p0;

    // R12: reset state
    tick(5);
    chk("R12 sda_oe in reset", {7'b0, sda_oe}, 8'h00);
    rst = 1'b0;
    tick(5);
    chk("R12 sda_oe", {7'b0, sda_oe}, 8'h00);
    chk("R12 reg_we", {7'b0, reg_we}, 8'h00);
    chk("R12 fifo_pop", {7'b0, fifo_pop}, 8'h00);
    chk("R12 reg_addr", {1'b0, reg_addr}, 8'h00);

    // R3: own address refused before startup, write does not land
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    chk("R3 nack before startup", {7'b0, a}, 8'h00);
    wr_byte(8'h10, a);
    wr_byte(8'h77, a);
    bus_stop();
    startup_done = 1'b1;
    tick(Q);

    // R2: foreign address ignored
    bus_start();
    wr_byte({7'h55, 1'b0}, a);
    chk("R2 foreign address nack", {7'b0, a}, 8'h00);
    wr_byte(8'h11, a);
    wr_byte(8'h66, a);
    bus_stop();

    rd1(8'h10, d);
    chk("R3 no write before startup", d, 8'h00);
    rd1(8'h11, d);
    chk("R2 no write for foreign address", d, 8'h00);

    // Table walk: R4, R5, R7
    for (int i = 0; i < NV; i++) begin
      wr1(VEC[i][15:8], VEC[i][7:0]);
      rd1({1'b0, VEC[i][14:8]}, d);
      chk("R4/R5/R7 table readback", d, VEC[i][7:0]);
    end

    // R6 / R7: burst write then burst read
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h20, a);
    wr_byte(8'h11, a);
    wr_byte(8'h22, a);
    wr_byte(8'h33, a);
    chk("R6 third data ack", {7'b0, a}, 8'h01);
    bus_stop();
    rd_setup(8'h20);
    rd_byte(1'b1, d); chk("R6/R7 burst byte 0", d, 8'h11);
    rd_byte(1'b1, d); chk("R6/R7 burst byte 1", d, 8'h22);
    rd_byte(1'b0, d); chk("R6/R7 burst byte 2", d, 8'h33);
    bus_stop();
    chk("R7/R11 released after nack and stop", {7'b0, sda_oe}, 8'h00);

    // R8: buffer window
    p0 = pops;
    rd_setup({1'b0, BUFA});
    rd_byte(1'b1, d); chk("R8 buffer byte 0", d, 8'hA0 + 8'(p0));
    rd_byte(1'b1, d); chk("R8 buffer byte 1", d, 8'hA1 + 8'(p0));
    rd_byte(1'b0, d); chk("R8 buffer byte 2", d, 8'hA2 + 8'(p0));
    bus_stop();
    chk("R8 pop count", 8'(pops - p0), 8'd3);
    chk("R8 pointer frozen", {1'b0, reg_addr}, {1'b0, BUFA});
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b0, d);
    bus_stop();
    chk("R8 read without index stays on buffer", d, 8'hA3 + 8'(p0));

    // R9: stop during last data bit
    wr1(8'h30, 8'h55);
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h30, a);
    for (int i = 7; i >= 1; i--) bit_cycle(i[0] ? 1'b1 : 1'b0, s);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
    rd1(8'h30, d);
    chk("R9 no partial commit", d, 8'h55);

    // R10: repeated start mid-byte
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h30, a);
    for (int i = 0; i < 4; i++) bit_cycle(1'b0, s);
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    chk("R10 address ack after restart", {7'b0, a}, 8'h01);
    wr_byte(8'h31, a);
    wr_byte(8'h99, a);
    bus_stop();
    rd1(8'h30, d);
    chk("R10 aborted byte not written", d, 8'h55);
    rd1(8'h31, d);
    chk("R10 write after restart", d, 8'h99);

    // R11: bytes after stop without start are ignored
    scl_m = 1'b0; tick(Q);
    wr_byte({DEV, 1'b0}, a);
    chk("R11 no ack without start", {7'b0, a}, 8'h00);
    bus_stop();
    chk("R11 idle release", {7'b0, sda_oe}, 8'h00);

    done = 1'b1;
    finish_up();
  end
endmodule